// File: doc/BRIEF.md
# JTAG scan to SPI flash bridge

The bridge sits behind a user instruction of a JTAG test access port. While that instruction is selected and the port is in its data-shift state, the bridge reads the serial data stream one bit per test clock. It turns one framed piece of that stream into a single SPI transaction to a serial flash. A frame begins with any number of zero bits, followed by a single one bit. Next comes a 32-bit transfer length, sent most significant bit first. The bridge then moves exactly that many payload bits to the flash. After the payload it stays quiet until the scan ends.

The zero bits that arrive first come from bypass registers placed ahead of the bridge in the chain. The bits shifted in after the payload push the flash's reply out through bypass registers placed behind it. Because of this, the host does not need to know the shape of the chain. It only has to count one bit of delay for each enabled device, and the bridge is one of them. SCLK is a gated copy of the test clock and the SPI link works in mode 0. MOSI changes on the falling clock edge and MISO is captured on the rising edge.

Top module: `jspi_bridge`

## Requirements
- R1: While reset is high and on the first cycle after it, cs_n is 1, tdo is 0 and sclk is 0.
- R2: While hunting for a frame, 0 bits on tdi are ignored with cs_n held at 1. The first 1 bit seen while sel and shift are both high is the start marker, and it never reaches MOSI.
- R3: The 32 bits after the marker form the transfer length, most significant bit first. cs_n stays at 1 during all of these bits.
- R4: For a length N greater than 0, sclk gives exactly N rising edges while cs_n is 0. The MOSI values at those edges are the N tdi bits that follow the length field, in the order they arrived.
- R5: MOSI changes only on the falling edge of tck. The MISO value seen on the rising sclk edge for payload bit k is presented on tdo right after the next rising tck edge, which is one tck after bit k was taken from tdi.
- R6: Once N payload bits have been sent, cs_n returns to 1. Any further tdi bits in the same scan, ones included, cause no sclk edge and leave tdo at 0.
- R7: Whenever no SPI bit was clocked on the previous rising edge, tdo is 0.
- R8: A length of 0 never drives cs_n low and produces no sclk edge.
- R9: If sel or shift goes low, the bridge returns to hunting for a marker, and cs_n is 1 by the next rising tck edge. A new frame after that is handled from scratch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; also the source of SCLK |
| rst | input | 1 | Synchronous active-high reset (TAP reset) |
| sel | input | 1 | The bridge's user instruction is selected |
| shift | input | 1 | TAP is in the data-shift state |
| tdi | input | 1 | Serial scan data in |
| miso | input | 1 | Serial data from the flash |
| tdo | output | 1 | Serial scan data out |
| sclk | output | 1 | SPI clock, tck gated by the transfer enable |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 1 | Active-low flash chip select |

## Verification
The assertions check the following on every cycle. cs_n stays high while the bridge hunts for the marker and while it receives the length field. cs_n stays high once a finished transfer has settled. tdo reads 0 on the cycle after any cycle with cs_n high. Losing sel or shift releases cs_n on the next edge. Some behaviour can only be shown by the bench's scenarios, where a flash model sits on the SPI pins. These are: the exact number of sclk edges for each length, including zero; the payload arriving on MOSI in order; the one-tck alignment of the reply on tdo; and the restart after an aborted scan.

// File: rtl/jspi_pkg.sv
package jspi_pkg;
  // Frame parser phases; order carries no meaning beyond the names
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,   // waiting for the first 1 bit
    ST_HDR  = 2'd1,   // collecting the length field
    ST_XFER = 2'd2,   // passing payload bits to the flash
    ST_DONE = 2'd3    // payload finished, rest of scan ignored
  } jspi_state_e;

  localparam int unsigned JSPI_LEN_W = 32;
endpackage

// File: rtl/jspi_frame_ctl.sv
module jspi_frame_ctl
  import jspi_pkg::*;
#(
  parameter int unsigned LEN_W = JSPI_LEN_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        live,     // sel and shift both high
  input  logic        tdi,
  output jspi_state_e state_o,
  output logic        go_o,     // one payload bit captured this edge
  output logic        bit_o     // the payload bit to launch
);
  localparam int unsigned HCNT_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;
  localparam logic [HCNT_W-1:0] HCNT_LAST = HCNT_W'(LEN_W - 1);
  localparam logic [LEN_W-1:0]  ONE       = LEN_W'(1);

  jspi_state_e       state_q;
  logic [HCNT_W-1:0] hcnt_q;
  logic [LEN_W-1:0]  cnt_q;      // header shifter, then remaining-bit counter
  logic [LEN_W-1:0]  hdr_next;
  logic              go_q;
  logic              bit_q;

  always_comb begin
    hdr_next = {cnt_q[LEN_W-2:0], tdi};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      hcnt_q  <= '0;
      cnt_q   <= '0;
      go_q    <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (!live) begin
        state_q <= ST_HUNT;
      end else begin
        unique case (state_q)
          ST_HUNT: begin
            if (tdi) begin
              state_q <= ST_HDR;
              hcnt_q  <= '0;
              cnt_q   <= '0;
            end
          end
          ST_HDR: begin
            cnt_q  <= hdr_next;
            hcnt_q <= hcnt_q + 1'b1;
            if (hcnt_q == HCNT_LAST) begin
              state_q <= (hdr_next == '0) ? ST_DONE : ST_XFER;
            end
          end
          ST_XFER: begin
            go_q  <= 1'b1;
            bit_q <= tdi;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == ONE) state_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign go_o    = go_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/jspi_spi_phy.sv
module jspi_spi_phy (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic bit_i,
  input  logic miso,
  output logic sclk,
  output logic mosi,
  output logic cs_n,
  output logic tdo
);
  logic en_q;     // changes only while clk is low, so the gate cannot glitch
  logic mosi_q;
  logic cs_n_q;
  logic tdo_q;

  // Falling-edge launch stage: chip select, data and clock enable
  always_ff @(negedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      cs_n_q <= 1'b1;
      mosi_q <= 1'b0;
    end else begin
      en_q   <= go_i;
      cs_n_q <= ~go_i;
      if (go_i) mosi_q <= bit_i;
    end
  end

  // Rising-edge capture of the flash reply
  always_ff @(posedge clk) begin
    if (rst) tdo_q <= 1'b0;
    else     tdo_q <= en_q ? miso : 1'b0;
  end

  assign sclk = clk & en_q;
  assign mosi = mosi_q;
  assign cs_n = cs_n_q;
  assign tdo  = tdo_q;
endmodule

// File: rtl/jspi_bridge.sv
module jspi_bridge
  import jspi_pkg::*;
#(
  parameter int unsigned LEN_W = JSPI_LEN_W
) (
  input  logic tck,
  input  logic rst,
  input  logic sel,
  input  logic shift,
  input  logic tdi,
  input  logic miso,
  output logic tdo,
  output logic sclk,
  output logic mosi,
  output logic cs_n
);
  jspi_state_e st;
  logic        go;
  logic        pbit;
  logic        live;

  assign live = sel & shift;

  jspi_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk     (tck),
    .rst     (rst),
    .live    (live),
    .tdi     (tdi),
    .state_o (st),
    .go_o    (go),
    .bit_o   (pbit)
  );

  jspi_spi_phy u_phy (
    .clk  (tck),
    .rst  (rst),
    .go_i (go),
    .bit_i(pbit),
    .miso (miso),
    .sclk (sclk),
    .mosi (mosi),
    .cs_n (cs_n),
    .tdo  (tdo)
  );
endmodule

// File: rtl/jspi_bridge_chk.sv
module jspi_bridge_chk
  import jspi_pkg::*;
(
  input logic        tck,
  input logic        rst,
  input logic        sel,
  input logic        shift,
  input logic        cs_n,
  input logic        tdo,
  input jspi_state_e state
);
  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (rst)
    cs_n |=> (tdo == 1'b0)); // R7

  AST_DESEL_RELEASE: assert property (@(posedge tck) disable iff (rst)
    !(sel && shift) |=> cs_n); // R9

  AST_HDR_NO_CS: assert property (@(posedge tck) disable iff (rst)
    (state == ST_HDR) |-> cs_n); // R3

  AST_HUNT_NO_CS: assert property (@(posedge tck) disable iff (rst)
    (state == ST_HUNT) |-> cs_n); // R2

  AST_DONE_HOLD: assert property (@(posedge tck) disable iff (rst)
    ((state == ST_DONE) && ($past(state) == ST_DONE)) |-> cs_n); // R6
endmodule

bind jspi_bridge jspi_bridge_chk u_chk (
  .tck   (tck),
  .rst   (rst),
  .sel   (sel),
  .shift (shift),
  .cs_n  (cs_n),
  .tdo   (tdo),
  .state (st)
);

// File: tb/tb_jspi_bridge.sv
`timescale 1ns/1ps
module tb_jspi_bridge;
  logic tck = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic shift = 1'b0;
  logic tdi = 1'b0;
  logic miso;
  logic tdo, sclk, mosi, cs_n;

  always #5 tck = ~tck;

  jspi_bridge dut (
    .tck(tck), .rst(rst), .sel(sel), .shift(shift), .tdi(tdi),
    .miso(miso), .tdo(tdo), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  localparam logic [63:0] RESP = 64'hC3A5_96F0_1E2D_7B48;

  int nchk = 0;
  int nfail = 0;

  // Flash model: captures MOSI on rising SCLK, advances reply on falling SCLK
  int   fidx = 0;
  int   rx_n = 0;
  int   cs_falls = 0;
  logic rx_bits [0:127];

  always @(negedge cs_n) begin fidx = 0; cs_falls++; end
  always @(negedge sclk) if (!cs_n) fidx++;
  always @(posedge sclk) begin
    if (rx_n < 128) rx_bits[rx_n] = mosi;
    rx_n++;
  end
  assign miso = cs_n ? 1'b0 : RESP[fidx % 64];

  // Scoreboard
  logic exp_q [$];
  bit   hdr_flag = 1'b0;
  bit   carry_v = 1'b0;
  int   carry_i = 0;

  initial begin
    forever begin
      @(posedge tck); #2;
      if (exp_q.size() > 0) begin
        logic e;
        e = exp_q.pop_front();
        nchk++;
        if (tdo !== e) begin
          nfail++;
          $display("FAIL R5/R7 tdo got %b exp %b at %0t", tdo, e, $time);
        end
      end
      if (hdr_flag) begin
        nchk++;
        if (cs_n !== 1'b1) begin
          nfail++;
          $display("FAIL R3 cs_n during length field got %b exp 1", cs_n);
        end
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic put_bit(input logic b, input bit is_data, input int didx, input bit hdr);
    @(negedge tck);
    sel = 1'b1; shift = 1'b1; tdi = b; hdr_flag = hdr;
    exp_q.push_back(carry_v ? RESP[carry_i % 64] : 1'b0);
    carry_v = is_data; carry_i = didx;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge tck);
      sel = 1'b0; shift = 1'b0; tdi = 1'b0; hdr_flag = 1'b0;
      exp_q.push_back(carry_v ? RESP[carry_i % 64] : 1'b0);
      carry_v = 1'b0;
    end
  endtask

  // lead zeros, marker, length, sent payload bits, trailing ones
  task automatic frame(input int lead, input logic [31:0] len, input int sent,
                       input logic [63:0] data, input int trail);
    rx_n = 0; cs_falls = 0;
    for (int i = 0; i < lead; i++) put_bit(1'b0, 1'b0, 0, 1'b0);
    put_bit(1'b1, 1'b0, 0, 1'b0);
    for (int i = 31; i >= 0; i--) put_bit(len[i], 1'b0, 0, 1'b1);
    for (int i = 0; i < sent; i++) put_bit(data[i % 64], 1'b1, i, 1'b0);
    for (int i = 0; i < trail; i++) put_bit(1'b1, 1'b0, 0, 1'b0);
    idle(3);
  endtask

  task automatic check_rx(input string req, input int n, input logic [63:0] data);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rx_bits[i] !== data[i % 64]) bad++;
    check(req, bad, 0);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge tck);
    #2;
    check("R1 cs_n in reset", cs_n, 1);
    check("R1 tdo in reset", tdo, 0);
    check("R1 sclk in reset", sclk, 0);
    @(negedge tck); rst = 1'b0;
    @(posedge tck); #2;
    check("R1 cs_n after reset", cs_n, 1);
    check("R1 tdo after reset", tdo, 0);

    // R2 R4: no leading zeros, 8 bits
    frame(0, 32'd8, 8, 64'hA5, 4);
    check("R4 sclk edges len8", rx_n, 8);
    check_rx("R4 mosi order len8", 8, 64'hA5);
    check("R6 cs_n after len8", cs_n, 1);

    // R2: three bypass zeros ahead, 13 bits
    frame(3, 32'd13, 13, 64'h1B3C, 5);
    check("R2 sclk edges with lead zeros", rx_n, 13);
    check_rx("R2 marker not on mosi", 13, 64'h1B3C);

    // R8: zero length
    frame(2, 32'd0, 0, 64'h0, 6);
    check("R8 sclk edges len0", rx_n, 0);
    check("R8 cs_n falls len0", cs_falls, 0);

    // R3 R6: longer payload, ones after it must be ignored
    frame(1, 32'd40, 40, 64'h0000_00F0_5A3C_9617, 10);
    check("R3 R6 sclk edges len40", rx_n, 40);
    check_rx("R4 mosi order len40", 40, 64'h0000_00F0_5A3C_9617);
    check("R6 single cs_n window", cs_falls, 1);

    // R9: abort after 6 of 20 bits
    frame(0, 32'd20, 6, 64'h2D, 0);
    check("R9 sclk edges on abort", rx_n, 6);
    check("R9 cs_n released", cs_n, 1);
    check_rx("R9 partial mosi", 6, 64'h2D);

    // R9: fresh frame after abort, single bit
    frame(4, 32'd1, 1, 64'h1, 2);
    check("R9 restart sclk edges", rx_n, 1);
    check_rx("R9 restart mosi", 1, 64'h1);

    idle(3);
    @(posedge tck); #3;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule